// File: doc/BRIEF.md
# UART FIFO Watermark Interrupt Controller

This block is the interrupt side of a UART. It holds two 8-entry, 8-bit character queues: one feeds the transmit shifter and one collects characters from the receiver. It also holds the transmit and receive control words, the interrupt enable word and a read-only pending word. Each pending bit is a plain comparison of a queue's occupancy against a 3-bit threshold. The single interrupt line combines the pending bits with the enable bits through gates only, and nothing is latched.

Software reaches the registers through a 32-bit read/write port addressed by word index. Reads are combinational. The transmit side pushes characters in with `tx_push`, and the shifter takes them with `tx_pop`. The receiver presents characters with `rx_char_valid`, and software consumes them with `rx_pop`. When the receive enable is clear, incoming characters are thrown away.

Each queue tracks its fill level with a three-state machine whose states are S_EMPTY, S_PART and S_FULL. Its transitions are:
- FILL_FIRST: S_EMPTY to S_PART, on an accepted push.
- DRAIN_LAST: S_PART to S_EMPTY, when the count reaches 0.
- FILL_LAST: S_PART to S_FULL, when the count reaches the depth.
- DRAIN_FIRST: S_FULL to S_PART, on an accepted pop.
- HOLD: the state stays as it is in every other case.

Top module: `uart_wm_ctrl`

## Requirements
- R1: After reset every register reads 0, both queues are empty (`tx_avail`=0, `rx_avail`=0, `tx_space`=1) and `irq` is 0.
- R2: The word index selects the register. Index 2 is transmit control, with its threshold in bits [18:16]. Index 3 is receive control, with its enable in bit 0 and its threshold in bits [18:16]. Index 4 is the interrupt enable word, with the transmit enable in bit 0 and the receive enable in bit 1. Reserved bits and unmapped indices read 0, and writes to them have no effect.
- R3: The pending word at index 5 uses bit 0 for transmit and bit 1 for receive. It is read-only, and writing it changes nothing.
- R4: While the receive enable is 0, `rx_char_valid` adds nothing to the receive queue. A write to the enable takes effect from the following cycle, so a character that arrives in the same cycle as the write is judged by the old enable.
- R5: The transmit pending bit is 1 exactly when the transmit occupancy is strictly less than the transmit threshold.
- R6: The receive pending bit is 1 exactly when the receive occupancy is strictly greater than the receive threshold.
- R7: `irq` is the OR of (pending AND enable) over both bits. It follows the registered state in the same cycle and holds no memory of its own.
- R8: Each queue returns characters in arrival order. The head appears on `*_head` whenever `*_avail` is 1, and each queue holds up to 8 entries.
- R9: A push into a full queue is dropped. A pop from an empty queue changes nothing.
- R10: When a push and a pop arrive together, each is accepted on its own terms. With both accepted the count is unchanged. At full, only the pop is accepted (count becomes 7). At empty, only the push is accepted (count becomes 1).
- R11: `tx_space` is 1 exactly when the transmit queue holds fewer than 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_push | input | 1 | Enqueue a transmit character |
| tx_wdata | input | 8 | Transmit character to enqueue |
| tx_space | output | 1 | Transmit queue not full |
| tx_pop | input | 1 | Shifter takes the transmit head |
| tx_head | output | 8 | Transmit queue head |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_char_valid | input | 1 | Receiver presents a character |
| rx_char | input | 8 | Received character |
| rx_pop | input | 1 | Consume the receive head |
| rx_head | output | 8 | Receive queue head |
| rx_avail | output | 1 | Receive queue not empty |
| irq | output | 1 | Combined watermark interrupt |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a register write that clears the receive enable and a character arriving from the receiver. The bench drives both in one cycle and expects the character to be kept, and a second character one cycle later to be dropped. The second pair is a push and a pop on the transmit queue, at full, at a middle level and at empty. The bench judges the result by draining the queue, counting the entries and checking the surviving order against R10.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_PART  = 2'd1,
        S_FULL  = 2'd2
    } fill_state_t;

    localparam int          ADDR_W   = 3;
    localparam int          TH_W     = 3;
    localparam int          TH_LSB   = 16;
    localparam int          IRQ_N    = 2;
    localparam int          IRQ_TX   = 0;
    localparam int          IRQ_RX   = 1;

    localparam logic [ADDR_W-1:0] W_TXCTL = 3'd2;
    localparam logic [ADDR_W-1:0] W_RXCTL = 3'd3;
    localparam logic [ADDR_W-1:0] W_IEN   = 3'd4;
    localparam logic [ADDR_W-1:0] W_IPEND = 3'd5;

endpackage

// File: rtl/uwm_fifo.sv
module uwm_fifo
    import uwm_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic             not_empty,
    output logic             not_full,
    output logic [CNT_W-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    fill_state_t       state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [DW-1:0]     store [DEPTH];
    logic              take_in, give_out;

    assign take_in  = push && (state_q != S_FULL);
    assign give_out = pop  && (state_q != S_EMPTY);

    always_comb begin
        count_d = count_q;
        if (take_in && !give_out) begin
            count_d = count_q + 1'b1;
        end else if (give_out && !take_in) begin
            count_d = count_q - 1'b1;
        end
    end

    // Fill-level state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next fill level
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: if (take_in)                       state_d = S_PART;  // FILL_FIRST
            S_PART: begin
                if (count_d == CNT_FULL)                state_d = S_FULL;  // FILL_LAST
                else if (count_d == '0)                 state_d = S_EMPTY; // DRAIN_LAST
            end
            S_FULL:  if (give_out)                      state_d = S_PART;  // DRAIN_FIRST
            default:                                    state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            count_q <= count_d;
            if (take_in) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (give_out) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take_in) begin
            store[wr_ptr_q] <= push_data;
        end
    end

    // Outputs from the state register
    always_comb begin
        head      = store[rd_ptr_q];
        not_empty = (state_q != S_EMPTY);
        not_full  = (state_q != S_FULL);
        count     = count_q;
    end

endmodule

// File: rtl/uwm_regs.sv
module uwm_regs
    import uwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [IRQ_N-1:0]  pend,
    output logic [31:0]       rdata,
    output logic [TH_W-1:0]   tx_th,
    output logic [TH_W-1:0]   rx_th,
    output logic              rx_en,
    output logic [IRQ_N-1:0]  ien
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{wdata[31:TH_LSB+TH_W], wdata[TH_LSB-1:IRQ_N]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_th <= '0;
            rx_th <= '0;
            rx_en <= 1'b0;
            ien   <= '0;
        end else if (wr) begin
            unique case (addr)
                W_TXCTL: tx_th <= wdata[TH_LSB +: TH_W];
                W_RXCTL: begin
                    rx_th <= wdata[TH_LSB +: TH_W];
                    rx_en <= wdata[0];
                end
                W_IEN:   ien   <= wdata[IRQ_N-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            W_TXCTL: rdata[TH_LSB +: TH_W] = tx_th;
            W_RXCTL: begin
                rdata[TH_LSB +: TH_W] = rx_th;
                rdata[0]              = rx_en;
            end
            W_IEN:   rdata[IRQ_N-1:0] = ien;
            W_IPEND: rdata[IRQ_N-1:0] = pend;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/uwm_irq.sv
module uwm_irq
    import uwm_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [TH_W-1:0]  tx_th,
    input  logic [TH_W-1:0]  rx_th,
    input  logic [IRQ_N-1:0] ien,
    output logic [IRQ_N-1:0] pend,
    output logic             irq
);

    always_comb begin
        pend         = '0;
        pend[IRQ_TX] = (tx_count < CNT_W'(tx_th));
        pend[IRQ_RX] = (rx_count > CNT_W'(rx_th));
        irq          = |(pend & ien);
    end

endmodule

// File: rtl/uart_wm_ctrl.sv
module uart_wm_ctrl
    import uwm_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_push,
    input  logic [DW-1:0]     tx_wdata,
    output logic              tx_space,
    input  logic              tx_pop,
    output logic [DW-1:0]     tx_head,
    output logic              tx_avail,
    input  logic              rx_char_valid,
    input  logic [DW-1:0]     rx_char,
    input  logic              rx_pop,
    output logic [DW-1:0]     rx_head,
    output logic              rx_avail,
    output logic              irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] tx_count, rx_count;
    logic [TH_W-1:0]  tx_th, rx_th;
    logic             rx_en;
    logic [IRQ_N-1:0] ien, pend;
    logic             rx_accept;
    logic             rx_space_unused;

    assign rx_accept = rx_char_valid && rx_en;

    uwm_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .pend  (pend),
        .rdata (reg_rdata),
        .tx_th (tx_th),
        .rx_th (rx_th),
        .rx_en (rx_en),
        .ien   (ien)
    );

    uwm_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (tx_wdata),
        .pop       (tx_pop),
        .head      (tx_head),
        .not_empty (tx_avail),
        .not_full  (tx_space),
        .count     (tx_count)
    );

    uwm_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_accept),
        .push_data (rx_char),
        .pop       (rx_pop),
        .head      (rx_head),
        .not_empty (rx_avail),
        .not_full  (rx_space_unused),
        .count     (rx_count)
    );

    uwm_irq #(.CNT_W(CNT_W)) u_irq (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_th    (tx_th),
        .rx_th    (rx_th),
        .ien      (ien),
        .pend     (pend),
        .irq      (irq)
    );

endmodule

// File: rtl/uwm_checker.sv
module uwm_checker
    import uwm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic              tx_push,
    input logic              tx_pop,
    input logic              rx_pop,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_en,
    input logic [IRQ_N-1:0]  ien,
    input logic              irq
);

    p_ien_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == W_IEN) |=> $stable(ien));

    p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_pop) |=> $stable(rx_count));

    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != '0));

    p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_W'(DEPTH) && tx_push && !tx_pop) |=> (tx_count == CNT_W'(DEPTH)));

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0 && tx_pop && !tx_push) |=> (tx_count == '0));

    p_push_pop_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count != '0 && tx_count != CNT_W'(DEPTH) && tx_push && tx_pop) |=> $stable(tx_count));

endmodule

bind uart_wm_ctrl uwm_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .tx_push  (tx_push),
    .tx_pop   (tx_pop),
    .rx_pop   (rx_pop),
    .tx_count (tx_count),
    .rx_count (rx_count),
    .rx_en    (rx_en),
    .ien      (ien),
    .irq      (irq)
);

// File: tb/uart_wm_ctrl_bench.sv
module uart_wm_ctrl_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic        tx_space;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_head;
    logic        tx_avail;
    logic        rx_char_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_head;
    logic        rx_avail;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uart_wm_ctrl u_uart_wm_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
        .tx_wdata(tx_wdata), .tx_space(tx_space), .tx_pop(tx_pop),
        .tx_head(tx_head), .tx_avail(tx_avail), .rx_char_valid(rx_char_valid),
        .rx_char(rx_char), .rx_pop(rx_pop), .rx_head(rx_head),
        .rx_avail(rx_avail), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic txin(input logic [7:0] d);
        @(negedge clk);
        tx_push = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic txout();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic rxin(input logic [7:0] d);
        @(negedge clk);
        rx_char_valid = 1'b1; rx_char = d;
        @(negedge clk);
        rx_char_valid = 1'b0;
    endtask

    task automatic rxout();
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic drain_tx(output int n, output logic [7:0] last);
        n = 0; last = '0;
        while (tx_avail && n < 20) begin
            last = tx_head;
            txout();
            n++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 register after reset", d, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 tx_avail after reset", {31'b0, tx_avail}, 32'h0);
        chk("R1 rx_avail after reset", {31'b0, rx_avail}, 32'h0);
        chk("R1 tx_space after reset", {31'b0, tx_space}, 32'h1);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R2 rx control fields", d, 32'h0007_0001);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R2 tx control field", d, 32'h0007_0000);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R2 enable word", d, 32'h3);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, d); chk("R2 unmapped reads zero", d, 32'h0);
        rd(3'd5, d); chk("R5 tx pending 0<7, rx 0>7 false", d, 32'h1);
        chk("R7 irq with tx pending enabled", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
        rd(3'd2, d); chk("R2 tx control cleared", d, 32'h0);
    endtask

    task automatic t_pend_ro();
        logic [31:0] d;
        wr(3'd2, 32'h0007_0000);
        wr(3'd5, 32'h0);
        rd(3'd5, d); chk("R3 pending unchanged by write 0", d, 32'h1);
        wr(3'd5, 32'h3);
        rd(3'd5, d); chk("R3 pending unchanged by write 3", d, 32'h1);
        wr(3'd2, 32'h0);
        rd(3'd5, d); chk("R5 tx pending clears at threshold 0", d, 32'h0);
    endtask

    task automatic t_rx_gate();
        for (int i = 0; i < 3; i++) rxin(8'h11);
        chk("R4 disabled receive keeps queue empty", {31'b0, rx_avail}, 32'h0);
        wr(3'd3, 32'h1);
        rxin(8'hA5);
        chk("R4 enabled receive stores", {31'b0, rx_avail}, 32'h1);
        // write clearing enable in the same cycle as an arriving character
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0;
        rx_char_valid = 1'b1; rx_char = 8'h5A;
        @(negedge clk);
        reg_wr = 1'b0; rx_char = 8'h77;
        @(negedge clk);
        rx_char_valid = 1'b0;
        chk("R8 rx head first", {24'b0, rx_head}, 32'hA5);
        rxout();
        chk("R4 same-cycle char kept under old enable", {24'b0, rx_head}, 32'h5A);
        rxout();
        chk("R4 char after disable dropped", {31'b0, rx_avail}, 32'h0);
    endtask

    task automatic t_rx_wm();
        logic [31:0] d;
        wr(3'd3, 32'h0002_0001);
        wr(3'd4, 32'h2);
        rxin(8'h01); rxin(8'h02);
        rd(3'd5, d); chk("R6 rx count 2 not above 2", d, 32'h0);
        chk("R7 irq low below rx watermark", {31'b0, irq}, 32'h0);
        rxin(8'h03);
        rd(3'd5, d); chk("R6 rx count 3 above 2", d, 32'h2);
        chk("R7 irq on rx watermark", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h1);
        chk("R7 irq masked with rx pending", {31'b0, irq}, 32'h0);
        rxout();
        rd(3'd5, d); chk("R6 rx pending clears after pop", d, 32'h0);
        rxout(); rxout();
        chk("R8 rx drained", {31'b0, rx_avail}, 32'h0);
        wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    endtask

    task automatic t_tx_wm();
        logic [31:0] d;
        wr(3'd2, 32'h0003_0000);
        wr(3'd4, 32'h1);
        chk("R7 irq tx empty below 3", {31'b0, irq}, 32'h1);
        txin(8'h01); txin(8'h02);
        rd(3'd5, d); chk("R5 tx count 2 below 3", d, 32'h1);
        txin(8'h03);
        rd(3'd5, d); chk("R5 tx count 3 not below 3", d, 32'h0);
        chk("R7 irq low at tx count 3", {31'b0, irq}, 32'h0);
        txout();
        rd(3'd5, d); chk("R5 tx pending back after pop", d, 32'h1);
        txout(); txout();
        wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) txin(8'(8'h10 + i));
        chk("R11 tx_space low at 8", {31'b0, tx_space}, 32'h0);
        txin(8'hFF);
        for (int i = 0; i < 8; i++) begin
            chk("R8 tx order", {24'b0, tx_head}, 32'(8'h10 + i));
            txout();
        end
        chk("R9 push into full dropped", {31'b0, tx_avail}, 32'h0);
        txout();
        chk("R9 pop from empty leaves empty", {31'b0, tx_avail}, 32'h0);
        txin(8'h3C);
        chk("R9 queue usable after empty pop", {24'b0, tx_head}, 32'h3C);
        chk("R11 tx_space high below 8", {31'b0, tx_space}, 32'h1);
        txout();
    endtask

    task automatic t_push_pop();
        int n;
        logic [7:0] last;
        for (int i = 0; i < 8; i++) txin(8'(8'h20 + i));
        @(negedge clk);
        tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'hEE;
        @(negedge clk);
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R10 full push+pop leaves 7", {31'b0, tx_space}, 32'h1);
        chk("R10 full push+pop pops head", {24'b0, tx_head}, 32'h21);
        @(negedge clk);
        tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'hEF;
        @(negedge clk);
        tx_push = 1'b0; tx_pop = 1'b0;
        drain_tx(n, last);
        chk("R10 mid push+pop count unchanged", 32'(n), 32'd7);
        chk("R10 mid push+pop keeps pushed char last", {24'b0, last}, 32'hEF);
        @(negedge clk);
        tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'h99;
        @(negedge clk);
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R10 empty push+pop head", {24'b0, tx_head}, 32'h99);
        drain_tx(n, last);
        chk("R10 empty push+pop count 1", 32'(n), 32'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_pend_ro();
        t_rx_gate();
        t_rx_wm();
        t_tx_wm();
        t_full();
        t_push_pop();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule